// File: doc/BRIEF.md
# Guarded Self-Synchronizing Bit Scrambler

This block whitens a serial bit stream before it goes onto a line and restores it on the far side. The transmit path divides the data by 1 + x^-6 + x^-7, folding each data bit with the line bits sent six and seven transfers earlier. The receive path multiplies by the same polynomial, folding each received line bit with the line bits received six and seven transfers earlier. Any error or start-up mismatch in the receive path therefore works its way out after a bounded number of bits.

A plain scrambler of this kind can get stuck producing short repeating line patterns, for example from all-ones data. Both paths therefore carry an identical periodicity guard. It counts consecutive line bits that repeat the bit 9 or 12 transfers earlier. When the run reaches a set length, it inverts the next line bit. The guard and both delay lines look only at post-guard line bits, so the two ends take the same decisions and stay in lock.

Each path is a single-bit stream with valid/ready on both sides and no storage at its edge. The output is formed combinationally from the input bit and the registered state. Ready is passed straight back from the output side to the input side. A bit is consumed, and the state advances, only on a cycle where input valid and output ready are both high. Back-pressure from downstream therefore stalls the upstream source with no loss of state.

Top module: `gsc_top`

## Requirements
- R1: Reset clears the line history and the run counter of both paths. The first bit accepted by the scrambler after reset leaves on the line unchanged.
- R2: On each path, input ready equals output ready and output valid equals input valid. A bit transfers only when both are high. No state changes on a cycle without a transfer, even if the input data changes.
- R3: The scrambler line bit is the data bit XOR the line bit sent 6 transfers earlier XOR the line bit sent 7 transfers earlier XOR the guard inversion flag.
- R4: The descrambler data bit is the received line bit XOR the line bit received 6 transfers earlier XOR the one received 7 transfers earlier XOR the guard inversion flag.
- R5: Each path keeps a run count of transferred line bits that equal the line bit 9 transfers earlier or 12 transfers earlier. History positions not yet written since reset count as 0. A non-matching bit zeroes the count. When the count reaches 33, the next transferred line bit is inverted and the count returns to 0; that bit is not tested for a match. So all-zero data from reset gives line bits 0 to 32 at 0 and line bit 33 at 1.
- R6: A descrambler fed with the scrambler's line output from a common reset returns the original data bit for bit. This covers all-ones data and data built to force a line period of 9 or 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Data bit offered to the scrambler |
| tx_ready | output | 1 | Scrambler accepts the data bit |
| tx_data | input | 1 | Data bit to scramble |
| txl_valid | output | 1 | Line bit offered by the scrambler |
| txl_ready | input | 1 | Line side accepts the scrambler bit |
| txl_data | output | 1 | Scrambled line bit |
| rxl_valid | input | 1 | Line bit offered to the descrambler |
| rxl_ready | output | 1 | Descrambler accepts the line bit |
| rxl_data | input | 1 | Received line bit |
| rx_valid | output | 1 | Recovered data bit offered |
| rx_ready | input | 1 | Consumer accepts the recovered bit |
| rx_data | output | 1 | Recovered data bit |

## Verification
The guard inversion and a downstream stall can fall on the same cycle. The inversion is then pending while the line side refuses the bit, and it must land on exactly the next bit accepted, not on the cycle it became due. The bench loops the scrambler into the descrambler and throttles the consumer with a pseudo-random ready pattern. It also drives data computed to keep the line periodic, so the run counter keeps reaching its limit under stalls. A scoreboard compares each accepted line bit and each recovered bit with its own model.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  localparam int unsigned GSC_HIST     = 12; // line history depth
  localparam int unsigned GSC_TAP_NEAR = 6;  // polynomial tap x^-6
  localparam int unsigned GSC_TAP_FAR  = 7;  // polynomial tap x^-7
  localparam int unsigned GSC_PER_A    = 9;  // first guarded period
  localparam int unsigned GSC_PER_B    = 12; // second guarded period
  localparam int unsigned GSC_RUN      = 33; // matches before forced inversion
endpackage

// File: rtl/gsc_guard.sv
module gsc_guard #(
  parameter int unsigned HIST  = gsc_pkg::GSC_HIST,
  parameter int unsigned PER_A = gsc_pkg::GSC_PER_A,
  parameter int unsigned PER_B = gsc_pkg::GSC_PER_B,
  parameter int unsigned RUN   = gsc_pkg::GSC_RUN,
  localparam int unsigned CW   = $clog2(RUN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            line_bit,
  output logic [HIST:1]   hist,
  output logic            inv,
  output logic [CW-1:0]   run_cnt
);
  logic match;

  // a full run arms the inversion for the next accepted bit
  assign inv   = (run_cnt == CW'(RUN));
  assign match = (line_bit == hist[PER_A]) || (line_bit == hist[PER_B]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= '0;
      run_cnt <= '0;
    end else if (adv) begin
      hist <= {hist[HIST-1:1], line_bit};
      if (inv)        run_cnt <= '0;
      else if (match) run_cnt <= run_cnt + CW'(1);
      else            run_cnt <= '0;
    end
  end
endmodule

// File: rtl/gsc_scrambler.sv
module gsc_scrambler #(
  parameter int unsigned HIST     = gsc_pkg::GSC_HIST,
  parameter int unsigned TAP_NEAR = gsc_pkg::GSC_TAP_NEAR,
  parameter int unsigned TAP_FAR  = gsc_pkg::GSC_TAP_FAR,
  parameter int unsigned PER_A    = gsc_pkg::GSC_PER_A,
  parameter int unsigned PER_B    = gsc_pkg::GSC_PER_B,
  parameter int unsigned RUN      = gsc_pkg::GSC_RUN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_bit,
  output logic m_valid,
  input  logic m_ready,
  output logic m_bit
);
  localparam int unsigned CW = $clog2(RUN + 1);
  logic [HIST:1] hist;
  logic          inv;
  logic [CW-1:0] run_cnt;
  logic          line;

  // divide by the polynomial: feedback from post-guard line bits
  assign line    = s_bit ^ hist[TAP_NEAR] ^ hist[TAP_FAR] ^ inv;
  assign m_bit   = line;
  assign m_valid = s_valid;
  assign s_ready = m_ready;

  gsc_guard #(.HIST(HIST), .PER_A(PER_A), .PER_B(PER_B), .RUN(RUN)) u_guard (
    .clk(clk), .rst_n(rst_n), .adv(s_valid & m_ready), .line_bit(line),
    .hist(hist), .inv(inv), .run_cnt(run_cnt)
  );
endmodule

// File: rtl/gsc_descrambler.sv
module gsc_descrambler #(
  parameter int unsigned HIST     = gsc_pkg::GSC_HIST,
  parameter int unsigned TAP_NEAR = gsc_pkg::GSC_TAP_NEAR,
  parameter int unsigned TAP_FAR  = gsc_pkg::GSC_TAP_FAR,
  parameter int unsigned PER_A    = gsc_pkg::GSC_PER_A,
  parameter int unsigned PER_B    = gsc_pkg::GSC_PER_B,
  parameter int unsigned RUN      = gsc_pkg::GSC_RUN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_bit,
  output logic m_valid,
  input  logic m_ready,
  output logic m_bit
);
  localparam int unsigned CW = $clog2(RUN + 1);
  logic [HIST:1] hist;
  logic          inv;
  logic [CW-1:0] run_cnt;

  // undo the guard flip, then multiply by the polynomial (feed-forward)
  assign m_bit   = s_bit ^ inv ^ hist[TAP_NEAR] ^ hist[TAP_FAR];
  assign m_valid = s_valid;
  assign s_ready = m_ready;

  gsc_guard #(.HIST(HIST), .PER_A(PER_A), .PER_B(PER_B), .RUN(RUN)) u_guard (
    .clk(clk), .rst_n(rst_n), .adv(s_valid & m_ready), .line_bit(s_bit),
    .hist(hist), .inv(inv), .run_cnt(run_cnt)
  );
endmodule

// File: rtl/gsc_top.sv
module gsc_top #(
  parameter int unsigned HIST     = gsc_pkg::GSC_HIST,
  parameter int unsigned TAP_NEAR = gsc_pkg::GSC_TAP_NEAR,
  parameter int unsigned TAP_FAR  = gsc_pkg::GSC_TAP_FAR,
  parameter int unsigned PER_A    = gsc_pkg::GSC_PER_A,
  parameter int unsigned PER_B    = gsc_pkg::GSC_PER_B,
  parameter int unsigned RUN      = gsc_pkg::GSC_RUN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_valid,
  output logic tx_ready,
  input  logic tx_data,
  output logic txl_valid,
  input  logic txl_ready,
  output logic txl_data,
  input  logic rxl_valid,
  output logic rxl_ready,
  input  logic rxl_data,
  output logic rx_valid,
  input  logic rx_ready,
  output logic rx_data
);
  gsc_scrambler #(.HIST(HIST), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR),
                  .PER_A(PER_A), .PER_B(PER_B), .RUN(RUN)) u_scr (
    .clk(clk), .rst_n(rst_n),
    .s_valid(tx_valid), .s_ready(tx_ready), .s_bit(tx_data),
    .m_valid(txl_valid), .m_ready(txl_ready), .m_bit(txl_data)
  );

  gsc_descrambler #(.HIST(HIST), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR),
                    .PER_A(PER_A), .PER_B(PER_B), .RUN(RUN)) u_dsc (
    .clk(clk), .rst_n(rst_n),
    .s_valid(rxl_valid), .s_ready(rxl_ready), .s_bit(rxl_data),
    .m_valid(rx_valid), .m_ready(rx_ready), .m_bit(rx_data)
  );
endmodule

// File: rtl/gsc_top_chk.sv
module gsc_top_chk #(
  parameter int unsigned HIST = gsc_pkg::GSC_HIST,
  parameter int unsigned RUN  = gsc_pkg::GSC_RUN,
  localparam int unsigned CW  = $clog2(RUN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_fire,
  input logic          tx_inv,
  input logic [CW-1:0] tx_cnt,
  input logic [HIST:1] tx_hist,
  input logic          rx_fire,
  input logic [CW-1:0] rx_cnt,
  input logic [HIST:1] rx_hist
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tx_cnt == '0) && (tx_hist == '0) && (rx_cnt == '0) && (rx_hist == '0));

  assert_tx_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_fire |=> $stable(tx_cnt) && $stable(tx_hist));

  assert_rx_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_fire |=> $stable(rx_cnt) && $stable(rx_hist));

  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(RUN));

  assert_flip_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && tx_inv) |=> (tx_cnt == '0) && !tx_inv);
endmodule

bind gsc_top gsc_top_chk #(.HIST(HIST), .RUN(RUN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_fire(tx_valid & txl_ready), .tx_inv(u_scr.u_guard.inv),
  .tx_cnt(u_scr.u_guard.run_cnt), .tx_hist(u_scr.u_guard.hist),
  .rx_fire(rxl_valid & rx_ready),
  .rx_cnt(u_dsc.u_guard.run_cnt), .rx_hist(u_dsc.u_guard.hist)
);

// File: tb/gsc_top_test.sv
module gsc_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0, tx_data = 1'b0, rx_ready = 1'b1;
  logic tx_ready, txl_valid, txl_ready, txl_data;
  logic rxl_valid, rxl_ready, rxl_data, rx_valid, rx_data;

  always #5 clk = ~clk;

  // loop the line side straight back
  assign rxl_valid = txl_valid;
  assign rxl_data  = txl_data;
  assign txl_ready = rxl_ready;

  gsc_top uut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .txl_valid(txl_valid), .txl_ready(txl_ready), .txl_data(txl_data),
    .rxl_valid(rxl_valid), .rxl_ready(rxl_ready), .rxl_data(rxl_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model of the line stream, written from the requirements
  bit [12:1] mh;
  int mcnt, mfires;
  bit exp_line_q[$];
  bit exp_data_q[$];

  task automatic model_reset();
    mh = '0; mcnt = 0; mfires = 0;
  endtask

  task automatic model_push(input bit d);
    bit flip, ln, m;
    flip = (mcnt == 33);
    ln = d ^ mh[6] ^ mh[7] ^ flip;
    m = (ln == mh[9]) || (ln == mh[12]);
    if (flip) begin mcnt = 0; mfires++; end
    else if (m) mcnt++;
    else mcnt = 0;
    mh = {mh[11:1], ln};
    exp_line_q.push_back(ln);
    exp_data_q.push_back(d);
  endtask

  // stall pattern: 0 always ready, 1 pseudo-random, 2 never ready
  int stall_mode = 0;
  bit [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (stall_mode)
      0: rx_ready = 1'b1;
      1: rx_ready = lfsr[0] | lfsr[3];
      default: rx_ready = 1'b0;
    endcase
  end

  // driver: presents one bit and holds it until it is accepted
  task automatic send_bit(input bit d);
    tx_valid = 1'b1;
    tx_data  = d;
    model_push(d);
    forever begin
      @(negedge clk);
      if (rx_ready) begin
        @(posedge clk);
        #2;
        break;
      end
    end
    tx_valid = 1'b0;
  endtask

  // monitor / scoreboard
  int acc_idx = 0;
  bit obs [0:63];
  always @(negedge clk) begin
    if (rst_n && tx_valid && txl_ready) begin
      bit el, ed;
      if (exp_line_q.size() == 0) begin
        chk(1'b0, "R2 unexpected transfer", 1, 0);
      end else begin
        el = exp_line_q.pop_front();
        ed = exp_data_q.pop_front();
        // R3 line equation, R5 inversion included in the model
        chk(txl_data == el, "R3/R5 line bit", int'(txl_data), int'(el));
        // R4 descrambling, R6 round trip
        chk(rx_valid && rx_data == ed, "R4/R6 recovered bit", int'(rx_data), int'(ed));
        if (acc_idx < 64) obs[acc_idx] = txl_data;
        acc_idx++;
      end
    end
  end

  task automatic do_reset();
    tx_valid = 1'b0;
    @(posedge clk); #2;
    rst_n = 1'b0;
    model_reset();
    acc_idx = 0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  // data that would keep the line periodic if the guard did nothing
  task automatic send_periodic(input int per, input bit [11:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      bit want;
      want = pat[i % per];
      send_bit(want ^ mh[6] ^ mh[7]);
    end
  endtask

  initial begin
    bit [15:0] dg;
    do_reset();
    // R1: idle after reset, nothing offered
    @(negedge clk);
    chk(txl_valid == 1'b0 && rx_valid == 1'b0, "R1 idle valid", int'(txl_valid), 0);
    chk(tx_ready == 1'b1, "R1 ready with consumer ready", int'(tx_ready), 1);

    // R2: consumer refuses, input wiggles, nothing transfers
    @(posedge clk); #2;
    stall_mode = 2;
    @(posedge clk); #2;
    tx_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tx_data = i[0];
      @(negedge clk);
      chk(tx_ready == 1'b0, "R2 ready follows stall", int'(tx_ready), 0);
      chk(txl_valid == 1'b1 && rx_valid == 1'b1, "R2 valid passes", int'(txl_valid), 1);
      @(posedge clk); #2;
    end
    tx_valid = 1'b0;
    stall_mode = 0;
    @(posedge clk); #2;

    // R1 first bit leaves unchanged; R6 all-ones round trip under stalls
    stall_mode = 1;
    for (int i = 0; i < 300; i++) send_bit(1'b1);
    chk(obs[0] == 1'b1, "R1 first line bit", int'(obs[0]), 1);

    // R5: all-zero data from reset fires exactly at line bit 33
    stall_mode = 0;
    do_reset();
    for (int i = 0; i < 40; i++) send_bit(1'b0);
    chk(obs[32] == 1'b0, "R5 line bit 32", int'(obs[32]), 0);
    chk(obs[33] == 1'b1, "R5 line bit 33 inverted", int'(obs[33]), 1);

    // R5/R6: period-9 and period-12 line patterns with stalls
    stall_mode = 1;
    do_reset();
    send_periodic(9, 12'b0001_1011_0011, 250);
    chk(mfires > 0, "R5 guard fired on period 9", mfires, 1);
    do_reset();
    send_periodic(12, 12'b1010_0111_0010, 250);
    chk(mfires > 0, "R5 guard fired on period 12", mfires, 1);

    // R6: pseudo-random data
    do_reset();
    dg = 16'h1D2B;
    for (int i = 0; i < 300; i++) begin
      dg = {dg[14:0], dg[15] ^ dg[14] ^ dg[12] ^ dg[3]};
      send_bit(dg[0]);
    end
    chk(exp_line_q.size() == 0, "R2 all bits consumed", exp_line_q.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule